// File: doc/BRIEF.md
# Erasure Pattern Rank Compressor

This block sits in front of the table of per-pattern correction matrices of an erasure-only block decoder. A codeword has N symbols, R of them check symbols. The block takes an N-bit erasure mask, where a set bit marks an erased symbol. It returns a dense table index. Only the C(N,R) masks that have exactly R bits set ever address the table, so the index is the combinatorial rank of the mask among those words. With N=14 and R=4 this gives 1001 entries, against 16384 for direct addressing.

A mask with fewer than R erasures is first completed to exactly R. The block marks still-clean check-symbol positions as erased, starting from the highest one. Doing so is harmless, because recomputing a symbol that is already known still yields a valid codeword. A mask with more than R erasures cannot be corrected, and the block flags it instead. Masks are accepted every cycle, and each result appears one clock later.

Top module: `erc_rank_compressor`

## Requirements
- R1: While reset is asserted, o_vld, o_ovf and o_rank are all zero.
- R2: o_vld in a cycle equals i_vld in the cycle before, so the latency is one clock.
- R3: For a valid mask with exactly R bits set, o_rank is the count of N-bit values that are numerically smaller than the mask and have exactly R bits set. The mask with its lowest R bits set gives 0. The mask with its highest R bits set gives C(N,R)-1.
- R4: When o_vld is high and o_ovf is low, o_rank is below C(N,R).
- R5: A valid mask with more than R bits set gives o_ovf=1 and o_rank=0 on the next cycle. A valid mask with R or fewer bits set gives o_ovf=0.
- R6: A valid mask with fewer than R bits set is padded before ranking. The check symbols occupy mask bits R-1 down to 0. Clear bits among them are set from bit R-1 downward until exactly R bits are set. o_rank is the R3 rank of the padded mask.
- R7: An all-zero valid mask is padded to bits R-1..0 and yields o_rank=0 with o_ovf=0.
- R8: When i_vld is low, i_mask is ignored: on the next cycle o_ovf and o_rank are both zero, whatever the mask.
- R9: A new mask can be accepted in every cycle. Back-to-back masks produce back-to-back results, each belonging to the mask of the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_vld | input | 1 | Mask qualifier |
| i_mask | input | N | Erasure mask, one bit per symbol, set = erased |
| o_vld | output | 1 | Result valid |
| o_rank | output | IDX_W = ceil(log2(C(N,R))) | Dense matrix-table index |
| o_ovf | output | 1 | More than R erasures, uncorrectable |

## Verification
The properties assume that i_mask is meaningful only while i_vld is high. They also assume that reset is released at a point where i_vld is low, so that the first cycle after reset carries no stale mask. The bench holds i_vld low throughout reset and drives masks only on falling edges. It mixes corner masks (empty, single erasure, erasures that already fall on check positions, all ones) with a pseudo-random stream presented every cycle. Expected ranks come from brute-force counting of the smaller fixed-weight words.

// File: rtl/erc_pkg.sv
package erc_pkg;

    // Binomial coefficient n over k, zero outside 0 <= k <= n.
    function automatic longint binom(input int n, input int k);
        longint r;
        if (k < 0 || k > n) return 0;
        r = 1;
        for (int t = 1; t <= k; t++) r = (r * longint'(n - k + t)) / longint'(t);
        return r;
    endfunction

    function automatic int width_of(input longint cnt);
        return (cnt > 1) ? $clog2(cnt) : 1;
    endfunction

endpackage

// File: rtl/erc_popcnt.sv
module erc_popcnt #(
    parameter int N  = 14,
    parameter int CW = 4
) (
    input  logic [N-1:0]  mask,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < N; i++) cnt = cnt + CW'(mask[i]);
    end
endmodule

// File: rtl/erc_pad.sv
module erc_pad #(
    parameter int N  = 14,
    parameter int R  = 4,
    parameter int CW = 4
) (
    input  logic [N-1:0]  mask,
    input  logic [CW-1:0] cnt,
    output logic [N-1:0]  padded
);
    // Check symbols sit at bits R-1..0; fill clear ones from the top.
    always_comb begin
        int need;
        padded = mask;
        need   = (int'(cnt) < R) ? (R - int'(cnt)) : 0;
        for (int j = R - 1; j >= 0; j--) begin
            if (!mask[j] && need > 0) begin
                padded[j] = 1'b1;
                need      = need - 1;
            end
        end
    end
endmodule

// File: rtl/erc_rank.sv
module erc_rank #(
    parameter int N     = 14,
    parameter int R     = 4,
    parameter int IDX_W = 10
) (
    input  logic [N-1:0]     mask,
    output logic [IDX_W-1:0] rank
);
    import erc_pkg::*;

    localparam int RW = (R > 0) ? $clog2(R + 1) : 1;

    // Coefficient grid C(i,j), evaluated at elaboration.
    logic [31:0] coef [N][R+1];

    for (genvar gi = 0; gi < N; gi++) begin : g_row
        for (genvar gj = 0; gj <= R; gj++) begin : g_col
            assign coef[gi][gj] = 32'(binom(gi, gj));
        end
    end

    // MSB-first scan: each set bit at i with r ones left adds C(i,r).
    always_comb begin
        logic [31:0]   acc;
        logic [RW-1:0] rem;
        acc = '0;
        rem = RW'(R);
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i] && rem != '0) begin
                acc = acc + coef[i][rem];
                rem = rem - 1'b1;
            end
        end
        rank = acc[IDX_W-1:0];
    end
endmodule

// File: rtl/erc_rank_compressor.sv
module erc_rank_compressor #(
    parameter int N = 14,
    parameter int R = 4,
    localparam int NUM_IDX = int'(erc_pkg::binom(N, R)),
    localparam int IDX_W   = erc_pkg::width_of(longint'(NUM_IDX))
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             i_vld,
    input  logic [N-1:0]     i_mask,
    output logic             o_vld,
    output logic [IDX_W-1:0] o_rank,
    output logic             o_ovf
);
    localparam int CW = $clog2(N + 1);

    typedef struct packed {
        logic             vld;
        logic             ovf;
        logic [IDX_W-1:0] idx;
    } res_t;

    res_t res_d, res_q;

    logic [CW-1:0]    ones;
    logic [N-1:0]     filled;
    logic [IDX_W-1:0] rank_w;

    erc_popcnt #(.N(N), .CW(CW)) u_popcnt (
        .mask (i_mask),
        .cnt  (ones)
    );

    erc_pad #(.N(N), .R(R), .CW(CW)) u_pad (
        .mask   (i_mask),
        .cnt    (ones),
        .padded (filled)
    );

    erc_rank #(.N(N), .R(R), .IDX_W(IDX_W)) u_rank (
        .mask (filled),
        .rank (rank_w)
    );

    always_comb begin
        logic too_many;
        too_many  = int'(ones) > R;
        res_d.vld = i_vld;
        res_d.ovf = i_vld && too_many;
        res_d.idx = (i_vld && !too_many) ? rank_w : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign o_vld  = res_q.vld;
    assign o_ovf  = res_q.ovf;
    assign o_rank = res_q.idx;

endmodule

// File: rtl/erc_rank_compressor_chk.sv
module erc_rank_compressor_chk #(
    parameter int N       = 14,
    parameter int R       = 4,
    parameter int NUM_IDX = 1001,
    parameter int IDX_W   = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             i_vld,
    input logic [N-1:0]     i_mask,
    input logic             o_vld,
    input logic [IDX_W-1:0] o_rank,
    input logic             o_ovf
);
    localparam logic [N-1:0] TOP_M = ~((N'(1) << (N - R)) - N'(1));
    localparam logic [N-1:0] LOW_M = (N'(1) << R) - N'(1);

    a_r2_valid_on: assert property (@(posedge clk) disable iff (!rst_n)
        i_vld |=> o_vld);
    a_r2_valid_off: assert property (@(posedge clk) disable iff (!rst_n)
        !i_vld |=> !o_vld);
    a_r3_lowest_rank: assert property (@(posedge clk) disable iff (!rst_n)
        (i_vld && i_mask == LOW_M) |=> (o_rank == '0 && !o_ovf));
    a_r3_highest_rank: assert property (@(posedge clk) disable iff (!rst_n)
        (i_vld && i_mask == TOP_M) |=> (int'(o_rank) == NUM_IDX - 1));
    a_r4_rank_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (o_vld && !o_ovf) |-> (int'(o_rank) < NUM_IDX));
    a_r5_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (i_vld && $countones(i_mask) > R) |=> (o_ovf && o_rank == '0));
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (i_vld && $countones(i_mask) <= R) |=> !o_ovf);
    a_r7_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (i_vld && i_mask == '0) |=> (o_rank == '0 && !o_ovf));
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !i_vld |=> (!o_ovf && o_rank == '0));
endmodule

bind erc_rank_compressor erc_rank_compressor_chk #(
    .N(N), .R(R), .NUM_IDX(NUM_IDX), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .i_vld(i_vld), .i_mask(i_mask),
    .o_vld(o_vld), .o_rank(o_rank), .o_ovf(o_ovf)
);

// File: tb/erc_rank_compressor_tb.sv
`timescale 1ns/1ps
module erc_rank_compressor_tb;
    localparam int N       = 14;
    localparam int R       = 4;
    localparam int NUM_IDX = 1001;
    localparam int IDX_W   = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             i_vld = 1'b0;
    logic [N-1:0]     i_mask = '0;
    logic             o_vld;
    logic [IDX_W-1:0] o_rank;
    logic             o_ovf;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    erc_rank_compressor #(.N(N), .R(R)) u_dut (
        .clk(clk), .rst_n(rst_n), .i_vld(i_vld), .i_mask(i_mask),
        .o_vld(o_vld), .o_rank(o_rank), .o_ovf(o_ovf)
    );

    // Padding per R6: fill clear bits R-1..0 from the top.
    function automatic int ref_pad(input int m);
        int need = R - $countones(m[N-1:0]);
        int p = m;
        for (int j = R - 1; j >= 0 && need > 0; j--)
            if (!p[j]) begin p[j] = 1'b1; need--; end
        return p;
    endfunction

    // Rank per R3: brute-force count of smaller weight-R words.
    function automatic int ref_rank(input int m);
        int c = 0;
        for (int v = 0; v < m; v++) if ($countones(v[N-1:0]) == R) c++;
        return c;
    endfunction

    function automatic int exp_rank(input int m);
        if ($countones(m[N-1:0]) > R) return 0;
        return ref_rank(ref_pad(m));
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_result(input string tag, input int m);
        chk({tag, " vld"}, int'(o_vld), 1);
        chk({tag, " ovf"}, int'(o_ovf), ($countones(m[N-1:0]) > R) ? 1 : 0);
        chk({tag, " rank"}, int'(o_rank), exp_rank(m));
    endtask

    task automatic apply(input string tag, input int m);
        @(negedge clk);
        i_vld  = 1'b1;
        i_mask = m[N-1:0];
        @(negedge clk);
        chk_result(tag, m);
        i_vld = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 vld in reset", int'(o_vld), 0);
        chk("R1 ovf in reset", int'(o_ovf), 0);
        chk("R1 rank in reset", int'(o_rank), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_extremes();
        apply("R3 lowest", 32'h000F);
        chk("R3 lowest is 0", int'(o_rank), 0);
        apply("R3 highest", 32'h3C00);
        chk("R3 highest is C-1", int'(o_rank), NUM_IDX - 1);
        apply("R3 mid", 32'h0A51);
        apply("R7 zero mask", 0);
        chk("R7 zero rank", int'(o_rank), 0);
    endtask

    task automatic t_padding();
        apply("R6 single high", 32'h2000);
        chk("R6 single high value", int'(o_rank), 718);
        apply("R6 on check pos", 32'h0408);
        apply("R6 low check", 32'h0001);
        apply("R6 three", 32'h1110);
        apply("R6 two checks", 32'h0006);
    endtask

    task automatic t_overflow();
        apply("R5 five bits", 32'h001F);
        apply("R5 all ones", 32'h3FFF);
        apply("R5 exactly R", 32'h2211);
    endtask

    task automatic t_idle();
        @(negedge clk);
        i_vld  = 1'b0;
        i_mask = '1;
        @(negedge clk);
        chk("R8 idle vld", int'(o_vld), 0);
        chk("R8 idle ovf", int'(o_ovf), 0);
        chk("R8 idle rank", int'(o_rank), 0);
        chk("R2 idle vld", int'(o_vld), 0);
    endtask

    task automatic t_stream();
        int prev = 0;
        for (int k = 0; k <= 64; k++) begin
            @(negedge clk);
            if (k > 0) chk_result("R9 stream", prev);
            if (k < 64) begin
                lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                prev  = (k % 3 == 0) ? int'(lfsr[N-1:0] & lfsr[15:2]) : int'(lfsr[N-1:0]);
                i_vld  = 1'b1;
                i_mask = prev[N-1:0];
            end else begin
                i_vld = 1'b0;
            end
        end
        @(negedge clk);
        chk("R2 stream end", int'(o_vld), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_extremes();
        t_padding();
        t_overflow();
        t_idle();
        t_stream();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule